// File: doc/BRIEF.md
# Deferred Condition-Code Evaluator

This block turns a recorded arithmetic event into updated condition codes. The caller keeps, per instruction, an operation class, an operand size, the source, destination and result values and the high word of any multiply. When the flags are needed it pulses a strobe with those values, an update mask and the present flag register. One clock later the block presents the merged flag register.

Flags are derived only from sign bits and a zero test, so no adder is needed except to rebuild word-size add and subtract results. Subtract and compare invert the source before evaluation and invert carry afterwards. A dedicated compare-style class writes a result flag into the carry slot. Multiplies judge overflow from the high product word, and move, logic and shift classes produce only negative and zero flags. The writeback always clears the extend flag. It keeps the old zero flag during extended arithmetic.

Top module: `cc_flag_eval`

## Requirements
- R1: After reset `newCcs` is 0. It is loaded on the rising edge where `evalStb` is 1 and holds its value when `evalStb` is 0.
- R2: The general sign rule uses size code 0 (bit 7, zero over bits 7:0), 1 (bit 15, bits 15:0) or 2 (bit 31, all bits). With a set result sign: N=1, V when both operand signs are clear, C when both are set. With a clear result sign: Z if the tested bits are zero, V when both operand signs are set, C when either is set. Flag positions are C=0, V=1, Z=2, N=3, X=4. Op code 15 (generic) and op code 3 (add-with-carry) use this rule.
- R3: Subtract (op 1) and compare (op 2) invert the source before the sign rule and invert C after it.
- R4: At size code 2, add (op 0) evaluates dst+src and subtract (op 1) evaluates dst-src in place of the recorded result. At other sizes the recorded result is used.
- R5: The compare-style class (op 4) applies the sign rule at 32 bits with no inversion whatever the size code. Its carry-slot output is the R flag.
- R6: Move and logic/shift classes (ops 7 to 13) at size code 1 or 2 give only N (top bit of the sized result) and Z (sized result zero). At size code 0 they follow the general rule.
- R7: Signed multiply (op 5) sets Z when {hiWord,result} is zero and N from its bit 63. It sets V when hiWord is not the sign extension of result bit 31.
- R8: Unsigned multiply (op 6) sets Z when {hiWord,result} is zero and N from hiWord bit 31. It sets V when hiWord is non-zero.
- R9: The writeback clears the masked bits and bit 4 (X) of `curCcs`, then ORs in the new flags ANDed with the mask. All other bits pass through unchanged.
- R10: When `curCcs` bit 4 is set, or the op is 3, bit 2 (Z) is dropped from the mask and keeps its old value.
- R11: Op 14 (live flags) loads `curCcs` unchanged, X included.
- R12: Size code 3 produces no sign-rule flags. Subtract and compare still yield C=1 from the final inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evalStb | input | 1 | Evaluate and load the flag register |
| opClass | input | 4 | Recorded operation class |
| opSize | input | 2 | Operand size code |
| srcVal | input | DATA_W | Recorded source operand |
| dstVal | input | DATA_W | Recorded destination operand |
| resVal | input | DATA_W | Recorded result |
| hiWord | input | DATA_W | High product word for multiplies |
| updMask | input | CCS_W | Flags allowed to change |
| curCcs | input | CCS_W | Present flag register |
| newCcs | output | CCS_W | Merged flag register, registered |

## Verification
The bench uses the default 32-bit data and flag-register widths with the default flag positions. At these values the byte, half and word sign positions are separate bits. The 64-bit multiply product runs through its full range of sign and zero cases. The upper bits of the flag register, which no flag occupies, show whether the merge leaves untouched bits alone. Random masks and flag registers drive the sticky-zero and extend-clear paths for every operation class.

// File: rtl/cc_flag_pkg.sv
`timescale 1ns/1ps
package cc_flag_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CMP = 4'd2, OP_ADDC = 4'd3,
    OP_MCP = 4'd4, OP_MULS = 4'd5, OP_MULU = 4'd6, OP_MOVE = 4'd7,
    OP_AND = 4'd8, OP_OR = 4'd9, OP_XOR = 4'd10, OP_ASR = 4'd11,
    OP_LSR = 4'd12, OP_LSL = 4'd13, OP_LIVE = 4'd14, OP_GEN = 4'd15
  } ccOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_NONE = 2'd3
  } ccSize_e;

  typedef enum logic [2:0] {
    RULE_SIGN, RULE_NZ, RULE_MCP, RULE_MULS, RULE_MULU, RULE_LIVE
  } ccRule_e;

  typedef struct packed {
    ccRule_e rule;
    logic    invSrc;
    logic    invC;
    logic    recAdd;
    logic    recSub;
    logic    holdZ;
  } ctrlStb_t;
endpackage

// File: rtl/cc_flag_ctrl.sv
`timescale 1ns/1ps
module cc_flag_ctrl
  import cc_flag_pkg::*;
(
  input  logic [3:0] opClass,
  input  logic [1:0] opSize,
  output ctrlStb_t   stb
);
  ccOp_e   op;
  ccSize_e sz;
  logic    isSubCmp;
  logic    isWord;

  assign op       = ccOp_e'(opClass);
  assign sz       = ccSize_e'(opSize);
  assign isSubCmp = (op == OP_SUB) || (op == OP_CMP);
  assign isWord   = (sz == SZ_WORD);

  always_comb begin
    stb        = '0;
    stb.rule   = RULE_SIGN;
    stb.holdZ  = (op == OP_ADDC);
    case (op)
      OP_LIVE: stb.rule = RULE_LIVE;
      OP_MCP:  stb.rule = RULE_MCP;
      OP_MULS: stb.rule = RULE_MULS;
      OP_MULU: stb.rule = RULE_MULU;
      OP_MOVE, OP_AND, OP_OR, OP_XOR, OP_ASR, OP_LSR, OP_LSL:
        stb.rule = (sz == SZ_HALF || sz == SZ_WORD) ? RULE_NZ : RULE_SIGN;
      default: begin
        stb.rule   = RULE_SIGN;
        stb.invSrc = isSubCmp;
        stb.invC   = isSubCmp;
        stb.recAdd = (op == OP_ADD) && isWord;
        stb.recSub = (op == OP_SUB) && isWord;
      end
    endcase
  end
endmodule

// File: rtl/cc_flag_dp.sv
`timescale 1ns/1ps
module cc_flag_dp
  import cc_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CCS_W  = 32,
  parameter int C_POS  = 0,
  parameter int V_POS  = 1,
  parameter int Z_POS  = 2,
  parameter int N_POS  = 3,
  parameter int X_POS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalStb,
  input  ctrlStb_t          stb,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] resVal,
  input  logic [DATA_W-1:0] hiWord,
  input  logic [CCS_W-1:0]  updMask,
  input  logic [CCS_W-1:0]  curCcs,
  output logic [CCS_W-1:0]  newCcs
);
  localparam int MSB   = DATA_W - 1;
  localparam int PROD_W = 2 * DATA_W;

  // returns {n, z, v, c}
  function automatic logic [3:0] signRule(input logic sS, input logic sD,
                                          input logic sR, input logic zr);
    logic [3:0] f;
    f = '0;
    if (sR) begin
      f[3] = 1'b1;
      f[1] = ~sS & ~sD;
      f[0] = sS & sD;
    end else begin
      f[2] = zr;
      f[1] = sS & sD;
      f[0] = sS | sD;
    end
    return f;
  endfunction

  logic [DATA_W-1:0] srcEff, resEff;
  logic [PROD_W-1:0] prod;
  logic [3:0]        nzvc;
  logic [CCS_W-1:0]  flagVec, effMask, merged;

  always_comb begin
    resEff = stb.recAdd ? (dstVal + srcVal) :
             stb.recSub ? (dstVal - srcVal) : resVal;
    srcEff = stb.invSrc ? ~srcVal : srcVal;
    prod   = {hiWord, resVal};
  end

  always_comb begin
    nzvc = '0;
    case (stb.rule)
      RULE_SIGN: begin
        case (ccSize_e'(opSize))
          SZ_BYTE: nzvc = signRule(srcEff[7], dstVal[7], resEff[7], resEff[7:0] == '0);
          SZ_HALF: nzvc = signRule(srcEff[15], dstVal[15], resEff[15], resEff[15:0] == '0);
          SZ_WORD: nzvc = signRule(srcEff[MSB], dstVal[MSB], resEff[MSB], resEff == '0);
          default: nzvc = '0;
        endcase
        if (stb.invC) nzvc[0] = ~nzvc[0];
      end
      RULE_MCP:
        nzvc = signRule(srcVal[MSB], dstVal[MSB], resVal[MSB], resVal == '0);
      RULE_NZ: begin
        if (ccSize_e'(opSize) == SZ_HALF) begin
          nzvc[3] = resVal[15];
          nzvc[2] = (resVal[15:0] == '0);
        end else begin
          nzvc[3] = resVal[MSB];
          nzvc[2] = (resVal == '0);
        end
      end
      RULE_MULS: begin
        nzvc[3] = prod[PROD_W-1];
        nzvc[2] = (prod == '0);
        nzvc[1] = resVal[MSB] ? (hiWord != '1) : (hiWord != '0);
      end
      RULE_MULU: begin
        nzvc[3] = hiWord[MSB];
        nzvc[2] = (prod == '0);
        nzvc[1] = |hiWord;
      end
      default: nzvc = '0;
    endcase
  end

  always_comb begin
    flagVec        = '0;
    flagVec[N_POS] = nzvc[3];
    flagVec[Z_POS] = nzvc[2];
    flagVec[V_POS] = nzvc[1];
    flagVec[C_POS] = nzvc[0];
    effMask        = updMask;
    if (stb.holdZ || curCcs[X_POS]) effMask[Z_POS] = 1'b0;
    merged         = curCcs & ~effMask;
    merged[X_POS]  = 1'b0;
    merged         = merged | (flagVec & effMask);
    if (stb.rule == RULE_LIVE) merged = curCcs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        newCcs <= '0;
    else if (evalStb) newCcs <= merged;
  end
endmodule

// File: rtl/cc_flag_eval.sv
`timescale 1ns/1ps
module cc_flag_eval
  import cc_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CCS_W  = 32,
  parameter int C_POS  = 0,
  parameter int V_POS  = 1,
  parameter int Z_POS  = 2,
  parameter int N_POS  = 3,
  parameter int X_POS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalStb,
  input  logic [3:0]        opClass,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] resVal,
  input  logic [DATA_W-1:0] hiWord,
  input  logic [CCS_W-1:0]  updMask,
  input  logic [CCS_W-1:0]  curCcs,
  output logic [CCS_W-1:0]  newCcs
);
  ctrlStb_t stb;

  cc_flag_ctrl u_ctrl (
    .opClass (opClass),
    .opSize  (opSize),
    .stb     (stb)
  );

  cc_flag_dp #(
    .DATA_W(DATA_W), .CCS_W(CCS_W), .C_POS(C_POS), .V_POS(V_POS),
    .Z_POS(Z_POS), .N_POS(N_POS), .X_POS(X_POS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evalStb (evalStb),
    .stb     (stb),
    .opSize  (opSize),
    .srcVal  (srcVal),
    .dstVal  (dstVal),
    .resVal  (resVal),
    .hiWord  (hiWord),
    .updMask (updMask),
    .curCcs  (curCcs),
    .newCcs  (newCcs)
  );
endmodule

// File: rtl/cc_flag_eval_chk.sv
`timescale 1ns/1ps
module cc_flag_eval_chk #(
  parameter int DATA_W = 32,
  parameter int CCS_W  = 32,
  parameter int V_POS  = 1,
  parameter int Z_POS  = 2,
  parameter int X_POS  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              evalStb,
  input logic [3:0]        opClass,
  input logic [DATA_W-1:0] hiWord,
  input logic [CCS_W-1:0]  updMask,
  input logic [CCS_W-1:0]  curCcs,
  input logic [CCS_W-1:0]  newCcs
);
  localparam logic [3:0] LIVE = 4'd14;
  localparam logic [3:0] ADDC = 4'd3;
  localparam logic [3:0] MULU = 4'd6;

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !evalStb |=> $stable(newCcs));

  p_live_pass_r11: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && opClass == LIVE) |=> newCcs == $past(curCcs));

  p_x_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && opClass != LIVE) |=> !newCcs[X_POS]);

  p_unmasked_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && opClass != LIVE && !updMask[Z_POS])
      |=> ((newCcs ^ $past(curCcs)) & ~$past(updMask) & ~(CCS_W'(1) << X_POS)) == '0);

  p_z_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && opClass != LIVE && (opClass == ADDC || curCcs[X_POS]))
      |=> newCcs[Z_POS] == $past(curCcs[Z_POS]));

  p_mulu_ovf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && opClass == MULU && updMask[V_POS])
      |=> newCcs[V_POS] == ($past(hiWord) != '0));
endmodule

bind cc_flag_eval cc_flag_eval_chk #(
  .DATA_W(DATA_W), .CCS_W(CCS_W), .V_POS(V_POS), .Z_POS(Z_POS), .X_POS(X_POS)
) u_chk (
  .clk(clk), .rstN(rstN), .evalStb(evalStb), .opClass(opClass),
  .hiWord(hiWord), .updMask(updMask), .curCcs(curCcs), .newCcs(newCcs)
);

// File: tb/cc_flag_eval_bench.sv
`timescale 1ns/1ps
module cc_flag_eval_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalStb = 1'b0;
  logic [3:0]  opClass = '0;
  logic [1:0]  opSize = '0;
  logic [31:0] srcVal = '0, dstVal = '0, resVal = '0, hiWord = '0;
  logic [31:0] updMask = '0, curCcs = '0;
  logic [31:0] newCcs;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cc_flag_eval u_cc_flag_eval (
    .clk(clk), .rstN(rstN), .evalStb(evalStb), .opClass(opClass),
    .opSize(opSize), .srcVal(srcVal), .dstVal(dstVal), .resVal(resVal),
    .hiWord(hiWord), .updMask(updMask), .curCcs(curCcs), .newCcs(newCcs)
  );

  // {n,z,v,c} from sign bits of operands and result at a given width
  function automatic logic [3:0] refSign(int bits, logic [31:0] a, logic [31:0] b,
                                         logic [31:0] r);
    logic sa, sb, sr, zr;
    logic [63:0] lowMask;
    lowMask = (64'd1 << bits) - 64'd1;
    sa = a[bits-1]; sb = b[bits-1]; sr = r[bits-1];
    zr = ((64'(r) & lowMask) == 64'd0);
    if (sr) return {1'b1, 1'b0, !sa && !sb, sa && sb};
    return {1'b0, zr, sa && sb, sa || sb};
  endfunction

  function automatic logic [31:0] refCcs(int op, int sz, logic [31:0] s,
      logic [31:0] d, logic [31:0] r, logic [31:0] m, logic [31:0] mask,
      logic [31:0] ccs);
    logic [3:0]  f;
    logic [31:0] w, rr, ss;
    logic [63:0] p;
    int bits;
    if (op == 14) return ccs;
    f = 4'b0;
    p = {m, r};
    if (op == 4) f = refSign(32, s, d, r);
    else if (op == 5) begin
      f[3] = p[63]; f[2] = (p == 64'd0);
      f[1] = (r[31] == 1'b1) ? (m != 32'hFFFF_FFFF) : (m != 32'd0);
    end else if (op == 6) begin
      f[3] = m[31]; f[2] = (p == 64'd0); f[1] = (m != 32'd0);
    end else if (op >= 7 && op <= 13 && (sz == 1 || sz == 2)) begin
      bits = (sz == 1) ? 16 : 32;
      f[3] = r[bits-1];
      f[2] = ((64'(r) & ((64'd1 << bits) - 64'd1)) == 64'd0);
    end else begin
      bits = (sz == 0) ? 8 : (sz == 1) ? 16 : (sz == 2) ? 32 : 0;
      rr = r;
      if (op == 0 && sz == 2) rr = d + s;
      if (op == 1 && sz == 2) rr = d - s;
      ss = (op == 1 || op == 2) ? ~s : s;
      if (bits != 0) f = refSign(bits, ss, d, rr);
      if (op == 1 || op == 2) f[0] = !f[0];
    end
    w = mask;
    if (op == 3 || ccs[4]) w[2] = 1'b0;
    return (ccs & ~(w | 32'h10)) | ({28'd0, f[3], f[2], f[1], f[0]} & w);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  task automatic runOne(string tag, int op, int sz, logic [31:0] s, logic [31:0] d,
      logic [31:0] r, logic [31:0] m, logic [31:0] mask, logic [31:0] ccs);
    @(negedge clk);
    opClass = 4'(op); opSize = 2'(sz); srcVal = s; dstVal = d; resVal = r;
    hiWord = m; updMask = mask; curCcs = ccs; evalStb = 1'b1;
    @(negedge clk);
    evalStb = 1'b0;
    check(tag, newCcs, refCcs(op, sz, s, d, r, m, mask, ccs));
  endtask

  function automatic logic [31:0] rndVal();
    logic [31:0] v;
    v = $urandom();
    case ($urandom_range(0, 7))
      0: v = 32'd0;
      1: v = {24'd0, v[7:0]};
      2: v = {16'd0, v[15:0]};
      3: v = 32'hFFFF_FFFF;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset value", newCcs, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: byte sign rule, low byte zero -> Z, V and C
    runOne("R2 byte both neg", 15, 0, 32'h80, 32'h80, 32'h100, 0, 32'h1F, 0);
    check("R2 byte literal", newCcs, 32'h7);
    runOne("R2 half neg result", 15, 1, 32'h0001, 32'h7FFF, 32'h8000, 0, 32'hF, 0);
    check("R2 half literal", newCcs, 32'hA);
    runOne("R2 word clear", 15, 2, 32'h1, 32'h2, 32'h3, 0, 32'hF, 0);
    // R3: subtract and compare
    runOne("R3 sub half", 1, 1, 32'h0005, 32'h0005, 32'h0000, 0, 32'hF, 0);
    check("R3 sub equal literal", newCcs, 32'h4);
    runOne("R3 cmp byte", 2, 0, 32'h01, 32'h00, 32'hFF, 0, 32'hF, 0);
    // R4: word add/sub rebuild ignores recorded result
    runOne("R4 add word rebuild", 0, 2, 32'hFFFF_FFFF, 32'h1, 32'h1234, 0, 32'hF, 0);
    check("R4 add wrap literal", newCcs, 32'h5);
    runOne("R4 sub word rebuild", 1, 2, 32'h2, 32'h1, 32'h0, 0, 32'hF, 0);
    runOne("R4 add half recorded", 0, 1, 32'h1, 32'h1, 32'h0, 0, 32'hF, 0);
    // R5: compare-style class, 32-bit regardless of size
    runOne("R5 mcp", 4, 0, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'hF, 0);
    check("R5 mcp literal", newCcs, 32'h7);
    // R6: move class
    runOne("R6 move half", 7, 1, 0, 0, 32'h1_0000, 0, 32'hF, 0);
    check("R6 move half literal", newCcs, 32'h4);
    runOne("R6 move word", 9, 2, 0, 0, 32'h8000_0000, 0, 32'hF, 0);
    runOne("R6 move byte general", 11, 0, 32'h80, 32'h80, 32'h80, 0, 32'hF, 0);
    // R7: signed multiply
    runOne("R7 muls sext ok", 5, 2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 32'hF, 0);
    check("R7 muls literal", newCcs, 32'h8);
    runOne("R7 muls ovf", 5, 2, 0, 0, 32'h8000_0000, 32'h0, 32'hF, 0);
    runOne("R7 muls zero", 5, 2, 0, 0, 0, 0, 32'hF, 0);
    // R8: unsigned multiply
    runOne("R8 mulu high", 6, 2, 0, 0, 32'h0, 32'h8000_0000, 32'hF, 0);
    check("R8 mulu literal", newCcs, 32'hA);
    // R9: partial mask, X cleared, other bits kept
    runOne("R9 partial mask", 15, 2, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000,
           0, 32'h2, 32'hABCD_0015);
    check("R9 partial literal", newCcs, 32'hABCD_0005);
    // R10: sticky Z
    runOne("R10 addc keeps Z", 3, 2, 0, 0, 0, 0, 32'hF, 32'h0);
    runOne("R10 X keeps Z", 15, 2, 0, 0, 0, 0, 32'hF, 32'h14);
    check("R10 X literal", newCcs, 32'h4);
    // R11: live
    runOne("R11 live", 14, 2, 32'h1, 32'h2, 32'h3, 32'h4, 32'hFFFF_FFFF, 32'h5A5A_001F);
    check("R11 live literal", newCcs, 32'h5A5A_001F);
    // R12: size code 3
    runOne("R12 sub none", 1, 3, 32'h8000_0000, 32'h8000_0000, 0, 0, 32'hF, 0);
    check("R12 sub none literal", newCcs, 32'h1);
    runOne("R12 gen none", 15, 3, 32'h8000_0000, 32'h8000_0000, 0, 0, 32'hF, 32'h8);

    // R1: hold while strobe low
    held = newCcs;
    @(negedge clk);
    curCcs = 32'hFFFF_FFFF; updMask = 32'hFFFF_FFFF; opClass = 4'd14;
    repeat (3) @(negedge clk);
    check("R1 hold", newCcs, held);

    for (int i = 0; i < 400; i++) begin
      runOne("R2 R9 random", int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
             rndVal(), rndVal(), rndVal(), rndVal(),
             {$urandom_range(0, 1) == 0 ? 27'd0 : 27'($urandom()), 5'($urandom())},
             $urandom());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule